// File: doc/BRIEF.md
# Power Mode and Watchdog Controller

This block sequences a processor core between its normal running state, a light sleep (idle) and a deep sleep (power-down), and owns the watchdog timer that guards the core. Software asks for a sleep state through two request strobes. The block then gates the CPU clock and, for deep sleep, switches the oscillator off. It wakes the core on the events each sleep state allows and decides, cycle by cycle, whether the watchdog may advance.

Resets come from three places: the system reset, a qualified external reset pin and the watchdog overflow. All three return the mode machine to the running state. The watchdog is a free-running up-counter that advances once per machine cycle, which is one clock cycle here. It is cleared by a service strobe. On overflow it emits a fixed-length reset pulse. The watchdog pauses during power-down. It pauses during idle when a freeze option is set. After a deep-sleep wake caused by an external interrupt pin, it also stays paused until that pin returns high.

Top module: `pwr_wdog_ctrl`

## Requirements
- R1: The reset pin counts as a reset only after it has been sampled high on RST_QUAL consecutive clock edges while `osc_stable_i` is high; a shorter high pulse, or one while the oscillator is not stable, leaves `core_rst_o` low.
- R2: Once qualified, `core_rst_o` stays high for as long as the reset pin stays high, and goes low in the same cycle the pin drops.
- R3: In power-down, `cpu_clk_en_o` is 0 and `osc_run_o` is 0 unless the reset pin is high, and the watchdog count does not advance.
- R4: Power-down ends only on a qualified reset or on a low level of an external interrupt pin whose enable bit was set on the entry edge; `irq_pend_i` and enable bits set later are ignored. Pin k is `xint_n_i[k]`, active low, enabled by `xint_en_i[k]`.
- R5: After an interrupt wake from power-down, `cpu_clk_en_o` stays 0 until `osc_stable_i` is seen high, and it returns to 1 on the following edge.
- R6: After an interrupt wake from power-down, the watchdog stays paused while any pin that caused the wake is still low; counting restarts on the edge after all of them read high.
- R7: In idle, `cpu_clk_en_o` is 0 and `osc_run_o` is 1; idle ends on the edge at which `irq_pend_i` is high.
- R8: With `wd_idle_freeze_i` low the watchdog keeps counting in idle; with it high the count holds during idle and resumes after idle ends.
- R9: When both requests are high in the running state, power-down is entered and idle is not.
- R10: The watchdog overflows on the 2^WD_BITS-th counting edge after it was last cleared. It then drives `wd_rst_o` and `core_rst_o` high for exactly WD_PULSE cycles. `wd_kick_i` clears the count to zero.
- R11: While `rst` is high, `core_rst_o` is 1. Right after it, the mode is running: `cpu_clk_en_o`=1, `osc_run_o`=1, `wd_rst_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per machine cycle |
| rst | input | 1 | Synchronous active-high system reset |
| rst_pin_i | input | 1 | External reset pin level, active high |
| osc_stable_i | input | 1 | Oscillator running and stable |
| req_idle_i | input | 1 | Software request to enter idle |
| req_pdown_i | input | 1 | Software request to enter power-down |
| wd_idle_freeze_i | input | 1 | 1 = pause the watchdog while idle |
| wd_kick_i | input | 1 | Watchdog service strobe |
| irq_pend_i | input | 1 | Any enabled interrupt pending |
| xint_en_i | input | NINT | Per-pin external interrupt enables |
| xint_n_i | input | NINT | External interrupt pin levels, active low |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| osc_run_o | output | 1 | Oscillator run enable |
| core_rst_o | output | 1 | Internal reset to the core |
| wd_rst_o | output | 1 | Watchdog timeout reset pulse |

## Verification
The bench builds the block with WD_BITS=6, WD_PULSE=4, RST_QUAL=2 and NINT=2. A 64-cycle watchdog period makes the overflow edge, the full pulse and the resume after each kind of pause reachable in a few hundred cycles, with exact edge counts. The two interrupt pins let one pin be enabled and the other not, so the latched-at-entry rule and the per-pin hold release are both exercised.

// File: rtl/pwr_wdog_pkg.sv
package pwr_wdog_pkg;

    typedef enum logic [1:0] {
        M_RUN   = 2'd0,
        M_IDLE  = 2'd1,
        M_PDOWN = 2'd2,
        M_WAKE  = 2'd3
    } pmode_e;

    typedef struct packed {
        logic cpu_clk_en;
        logic osc_run;
    } pwr_en_t;

    // A pin wakes power-down when it is low and was enabled at entry.
    function automatic logic wake_hit(input logic [7:0] pins_n, input logic [7:0] en_lat);
        return |(~pins_n & en_lat);
    endfunction

endpackage

// File: rtl/rst_qual.sv
module rst_qual #(
    parameter int QUAL = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic stable_i,
    output logic qual_o
);
    localparam int CW = $clog2(QUAL + 1);
    localparam logic [CW-1:0] QMAX = CW'(QUAL);

    logic [CW-1:0] run_q;
    logic          live;

    assign live = pin_i && stable_i;

    always_ff @(posedge clk) begin
        if (rst || !live)
            run_q <= '0;
        else if (run_q != QMAX)
            run_q <= run_q + 1'b1;
    end

    assign qual_o = (run_q == QMAX) && live;

    p_qual_hist_r1: assert property (@(posedge clk) disable iff (rst)
        qual_o |-> $past(pin_i && stable_i));
    p_drop_r2: assert property (@(posedge clk) disable iff (rst)
        !pin_i |-> !qual_o);

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import pwr_wdog_pkg::*;
#(
    parameter int NINT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rst_pin_i,
    input  logic            osc_stable_i,
    input  logic            req_idle_i,
    input  logic            req_pdown_i,
    input  logic            irq_pend_i,
    input  logic [NINT-1:0] xint_en_i,
    input  logic [NINT-1:0] xint_n_i,
    output pmode_e          mode_o,
    output pwr_en_t         en_o,
    output logic            wd_hold_o
);
    pmode_e          mode_q;
    logic [NINT-1:0] en_lat_q;
    logic [NINT-1:0] wake_mask_q;
    logic            hold_q;
    logic            hit;
    logic            released;

    assign hit      = wake_hit(8'(xint_n_i) | ~8'((1 << NINT) - 1), 8'(en_lat_q));
    assign released = ((xint_n_i & wake_mask_q) == wake_mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= M_RUN;
            en_lat_q    <= '0;
            wake_mask_q <= '0;
        end else begin
            unique case (mode_q)
                M_RUN: begin
                    if (req_pdown_i) begin
                        mode_q   <= M_PDOWN;
                        en_lat_q <= xint_en_i;
                    end else if (req_idle_i) begin
                        mode_q <= M_IDLE;
                    end
                end
                M_IDLE:  if (irq_pend_i) mode_q <= M_RUN;
                M_PDOWN: begin
                    if (hit) begin
                        mode_q      <= M_WAKE;
                        wake_mask_q <= ~xint_n_i & en_lat_q;
                    end
                end
                M_WAKE:  if (osc_stable_i) mode_q <= M_RUN;
                default: mode_q <= M_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= 1'b0;
        else if (mode_q == M_PDOWN && hit)
            hold_q <= 1'b1;
        else if (released)
            hold_q <= 1'b0;
    end

    assign mode_o        = mode_q;
    assign wd_hold_o     = hold_q;
    assign en_o.cpu_clk_en = (mode_q == M_RUN);
    assign en_o.osc_run    = (mode_q != M_PDOWN) || rst_pin_i;

    p_pd_prio_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_RUN && req_pdown_i && req_idle_i) |=> (mode_q == M_PDOWN));
    p_wake_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_WAKE && !osc_stable_i) |=> !en_o.cpu_clk_en);
    p_pd_stay_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_PDOWN && (xint_n_i | ~en_lat_q) == '1) |=> (mode_q == M_PDOWN));
    p_idle_run_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_IDLE && irq_pend_i) |=> en_o.cpu_clk_en);

endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
    parameter int WD_BITS  = 14,
    parameter int WD_PULSE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic kick_i,
    input  logic run_i,
    output logic fire_o
);
    localparam int PW = $clog2(WD_PULSE + 1);
    localparam logic [PW-1:0] PLOAD = PW'(WD_PULSE);

    logic [WD_BITS-1:0] cnt_q;
    logic [PW-1:0]      pls_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pls_q <= '0;
        end else if (pls_q != '0) begin
            pls_q <= pls_q - 1'b1;
            cnt_q <= '0;
        end else if (clr_i || kick_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            if (cnt_q == '1) begin
                cnt_q <= '0;
                pls_q <= PLOAD;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign fire_o = (pls_q != '0);

    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !kick_i && !clr_i && !fire_o) |=> (cnt_q == $past(cnt_q)));
    p_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (run_i && !kick_i && !clr_i && !fire_o && cnt_q == '1) |=> fire_o);
    p_kick_r10: assert property (@(posedge clk) disable iff (rst)
        kick_i |=> (cnt_q == '0));

endmodule

// File: rtl/pwr_wdog_ctrl.sv
module pwr_wdog_ctrl
    import pwr_wdog_pkg::*;
#(
    parameter int WD_BITS  = 14,
    parameter int WD_PULSE = 4,
    parameter int RST_QUAL = 2,
    parameter int NINT     = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rst_pin_i,
    input  logic            osc_stable_i,
    input  logic            req_idle_i,
    input  logic            req_pdown_i,
    input  logic            wd_idle_freeze_i,
    input  logic            wd_kick_i,
    input  logic            irq_pend_i,
    input  logic [NINT-1:0] xint_en_i,
    input  logic [NINT-1:0] xint_n_i,
    output logic            cpu_clk_en_o,
    output logic            osc_run_o,
    output logic            core_rst_o,
    output logic            wd_rst_o
);
    logic    pin_rst;
    logic    wd_fire;
    logic    any_rst;
    logic    wd_hold;
    logic    wd_run;
    pmode_e  mode;
    pwr_en_t en;

    rst_qual #(.QUAL(RST_QUAL)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .pin_i    (rst_pin_i),
        .stable_i (osc_stable_i),
        .qual_o   (pin_rst)
    );

    assign any_rst = rst || pin_rst || wd_fire;

    mode_fsm #(.NINT(NINT)) u_fsm (
        .clk          (clk),
        .rst          (any_rst),
        .rst_pin_i    (rst_pin_i),
        .osc_stable_i (osc_stable_i),
        .req_idle_i   (req_idle_i),
        .req_pdown_i  (req_pdown_i),
        .irq_pend_i   (irq_pend_i),
        .xint_en_i    (xint_en_i),
        .xint_n_i     (xint_n_i),
        .mode_o       (mode),
        .en_o         (en),
        .wd_hold_o    (wd_hold)
    );

    assign wd_run = (mode != M_PDOWN) && !wd_hold &&
                    !(mode == M_IDLE && wd_idle_freeze_i);

    wdog_cnt #(.WD_BITS(WD_BITS), .WD_PULSE(WD_PULSE)) u_wd (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (pin_rst),
        .kick_i (wd_kick_i),
        .run_i  (wd_run),
        .fire_o (wd_fire)
    );

    assign cpu_clk_en_o = en.cpu_clk_en;
    assign osc_run_o    = en.osc_run;
    assign core_rst_o   = any_rst;
    assign wd_rst_o     = wd_fire;

    p_pd_quiet_r3: assert property (@(posedge clk) disable iff (any_rst)
        (mode == M_PDOWN && $past(mode == M_PDOWN)) |-> (!wd_rst_o && !cpu_clk_en_o));
    p_fire_rst_r10: assert property (@(posedge clk) disable iff (rst)
        wd_rst_o |-> core_rst_o);

endmodule

// File: tb/pwr_wdog_ctrl_tb.sv
module pwr_wdog_ctrl_tb;
    localparam int NINT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_pin = 1'b0, stab = 1'b1, r_idle = 1'b0, r_pd = 1'b0;
    logic freeze = 1'b0, kick = 1'b0, irq = 1'b0;
    logic [NINT-1:0] xen = '0, xn = '1;
    logic cpu_en, osc_run, core_rst, wd_rst;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    pwr_wdog_ctrl #(.WD_BITS(6), .WD_PULSE(4), .RST_QUAL(2), .NINT(NINT)) u_dut (
        .clk(clk), .rst(rst), .rst_pin_i(rst_pin), .osc_stable_i(stab),
        .req_idle_i(r_idle), .req_pdown_i(r_pd), .wd_idle_freeze_i(freeze),
        .wd_kick_i(kick), .irq_pend_i(irq), .xint_en_i(xen), .xint_n_i(xn),
        .cpu_clk_en_o(cpu_en), .osc_run_o(osc_run), .core_rst_o(core_rst),
        .wd_rst_o(wd_rst)
    );

    // row: {idle, pdown, irq, xn[1:0], en[1:0], stable, exp_cpu, exp_osc}
    localparam int NROW = 9;
    localparam logic [9:0] TBL [NROW] = '{
        10'b1_0_0_11_00_1_0_1,   // R7 enter idle
        10'b0_0_0_11_00_1_0_1,   // R7 stays idle
        10'b0_0_1_11_00_1_1_1,   // R7 interrupt ends idle
        10'b1_1_0_11_01_1_0_0,   // R9 both requests -> power-down, R3
        10'b0_0_0_01_01_1_0_0,   // R4 pin 1 low but not enabled
        10'b0_0_1_01_11_1_0_0,   // R4 irq and late enable ignored
        10'b0_0_0_10_11_0_0_1,   // R4 pin 0 wakes, R5 gated
        10'b0_0_0_10_11_0_0_1,   // R5 still waiting for oscillator
        10'b0_0_0_10_11_1_1_1    // R5 oscillator stable -> run
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic watch(input int n, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (wd_rst) seen = 1'b1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; rst_pin = 1'b0; stab = 1'b1; r_idle = 1'b0; r_pd = 1'b0;
        freeze = 1'b0; kick = 1'b0; irq = 1'b0; xen = '0; xn = '1;
        step(2);
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit seen;
        @(negedge clk);
        step(3);
        check("R11 core_rst in reset", core_rst, 1);
        rst = 1'b0;
        #1;
        check("R11 core_rst after", core_rst, 0);
        check("R11 cpu_en", cpu_en, 1);
        check("R11 osc_run", osc_run, 1);
        check("R11 wd_rst", wd_rst, 0);

        // R10 overflow timing and pulse length
        step(63);
        check("R10 before overflow", wd_rst, 0);
        step(1);
        check("R10 overflow", wd_rst, 1);
        check("R10 core_rst with wd", core_rst, 1);
        step(3);
        check("R10 pulse last cycle", wd_rst, 1);
        step(1);
        check("R10 pulse end", wd_rst, 0);

        // R10 kicks keep it quiet
        do_reset();
        seen = 1'b0;
        for (int i = 0; i < 200; i++) begin
            kick = (i % 32 == 0);
            step(1);
            if (wd_rst) seen = 1'b1;
        end
        kick = 1'b0;
        check("R10 kicked no timeout", seen, 0);

        // table walk: idle, priority, power-down wake rules
        do_reset();
        kick = 1'b1;
        for (int r = 0; r < NROW; r++) begin
            {r_idle, r_pd, irq, xn, xen, stab} = TBL[r][9:2];
            step(1);
            check($sformatf("R7/R9/R4/R5 row%0d cpu_en", r), cpu_en, TBL[r][1]);
            check($sformatf("R3/R4/R7 row%0d osc_run", r), osc_run, TBL[r][0]);
        end
        kick = 1'b0;

        // R1 / R2 reset pin qualification
        do_reset();
        rst_pin = 1'b1;
        step(1);
        check("R1 one edge not enough", core_rst, 0);
        step(1);
        check("R2 qualified", core_rst, 1);
        step(1);
        check("R2 held", core_rst, 1);
        rst_pin = 1'b0;
        #1;
        check("R2 drops with pin", core_rst, 0);
        step(1);
        rst_pin = 1'b1;
        step(1);
        rst_pin = 1'b0;
        step(1);
        check("R1 glitch ignored", core_rst, 0);
        stab = 1'b0;
        rst_pin = 1'b1;
        step(3);
        check("R1 unstable osc ignored", core_rst, 0);
        rst_pin = 1'b0;
        stab = 1'b1;

        // R4 power-down exit by reset pin, R3 osc control
        do_reset();
        xen = 2'b01;
        kick = 1'b1;
        r_pd = 1'b1;
        step(1);
        r_pd = 1'b0;
        kick = 1'b0;
        check("R3 pd osc off", osc_run, 0);
        check("R3 pd cpu off", cpu_en, 0);
        rst_pin = 1'b1;
        #1;
        check("R3 pin restarts osc", osc_run, 1);
        step(3);
        rst_pin = 1'b0;
        #1;
        check("R4 reset exits pd", cpu_en, 1);

        // R3 / R6 watchdog in power-down and after interrupt wake
        do_reset();
        xen = 2'b01;
        kick = 1'b1;
        r_pd = 1'b1;
        step(1);
        r_pd = 1'b0;
        kick = 1'b0;
        watch(100, seen);
        check("R3 wd frozen in pd", seen, 0);
        xn = 2'b10;
        stab = 1'b0;
        step(6);
        check("R5 gated until stable", cpu_en, 0);
        stab = 1'b1;
        step(1);
        check("R5 runs once stable", cpu_en, 1);
        watch(100, seen);
        check("R6 wd held while pin low", seen, 0);
        xn = 2'b11;
        step(64);
        check("R6 before resumed overflow", wd_rst, 0);
        step(1);
        check("R6 resumed overflow", wd_rst, 1);

        // R8 freeze in idle
        do_reset();
        freeze = 1'b1;
        kick = 1'b1;
        r_idle = 1'b1;
        step(1);
        kick = 1'b0;
        r_idle = 1'b0;
        watch(100, seen);
        check("R8 frozen in idle", seen, 0);
        irq = 1'b1;
        step(1);
        irq = 1'b0;
        check("R7 idle exit", cpu_en, 1);
        step(63);
        check("R8 resume before overflow", wd_rst, 0);
        step(1);
        check("R8 resume overflow", wd_rst, 1);

        // R8 counting in idle by default
        do_reset();
        kick = 1'b1;
        r_idle = 1'b1;
        step(1);
        kick = 1'b0;
        r_idle = 1'b0;
        step(63);
        check("R8 idle counting pre", wd_rst, 0);
        check("R7 idle cpu gated", cpu_en, 0);
        step(1);
        check("R8 idle overflow", wd_rst, 1);
        step(1);
        check("R10 wd reset leaves idle", cpu_en, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule